// File: doc/BRIEF.md
# Two-Class Crosspoint Cell Selector

This block is a single crosspoint node in one output column of a switch whose arbitration is spread over the column. Cells reach the node from two sides. Local cells come from the node's own input port. Transit cells are handed down by the crosspoints above it. In every clock cycle (one cell slot) the node offers at most one cell downstream toward the output line, over a valid/ready handshake.

Each side is buffered twice, once for the high class and once for the low class. High-class cells are ordered by age. Each one carries a saturating delay count that grows by one for every slot it waits, and the older of the two high-class heads goes first. Low-class cells are not ordered by that count, because it is too narrow to be fair over long waits. The low-class transit buffer is split into one virtual queue per upstream input. A rotating ring arbiter serves the local low-class queue and those virtual queues in turn, which shares the throughput fairly among the sources.

Top module: `xp_cell_sel`

## Requirements
- R1: After reset all queues are empty, `dn_valid` is low, `loc_ready` and `up_ready` are high for both classes, and the ring pointer rests on the local low-class queue.
- R2: A high-class cell (`*_hi` = 1) waiting in either buffer is always offered before any low-class cell in the same cycle.
- R3: The local side and the transit side each have a separate high-class queue and separate low-class storage, and every queue holds `DEPTH` cells. `loc_ready` follows the queue picked by `loc_hi`. `up_ready` follows the high transit queue when `up_hi` = 1 and the virtual queue picked by `up_src` when `up_hi` = 0. A cell offered while ready is low is dropped.
- R4: When both high-class heads are present, the head with the larger delay count is offered. On equal counts the transit head wins.
- R5: A local high-class cell enters with delay 0. A transit high-class cell enters with the delay it arrives with. While queued, the delay rises by one on every clock edge and stops at 2^DLY_W−1.
- R6: A low-class transit cell is stored in virtual queue `up_src` (0 to N_UP−1). Within a queue, cells leave in arrival order.
- R7: The ring order is position 0 for the local low-class queue and position k+1 for virtual queue k. The grant goes to the first non-empty position at or after the pointer, wrapping around, so empty queues are skipped. After a low-class cell is forwarded, the pointer moves to the position just past the grant.
- R8: The ring pointer does not move when a high-class cell is forwarded or when the offer is stalled by `dn_ready` = 0.
- R9: `dn_valid` is low exactly when every queue is empty. `dn_src` is the upstream input number for transit cells and N_UP for local cells. `dn_hi` gives the class.
- R10: The delay field of a low-class cell leaves the node unchanged from the value it arrived with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one cell slot |
| rst_n | input | 1 | Active-low synchronous reset |
| loc_valid | input | 1 | Local cell offered |
| loc_ready | output | 1 | Queue for the offered local class has room |
| loc_hi | input | 1 | Class of local cell, 1 = high |
| loc_tag | input | TAG_W | Local cell tag |
| up_valid | input | 1 | Transit cell offered by the upstream node |
| up_ready | output | 1 | Target transit queue has room |
| up_hi | input | 1 | Class of transit cell, 1 = high |
| up_tag | input | TAG_W | Transit cell tag |
| up_src | input | SRC_W | Input port the transit cell came from |
| up_dly | input | DLY_W | Delay count carried by the transit cell |
| dn_valid | output | 1 | A cell is offered downstream |
| dn_ready | input | 1 | Downstream accepts the offer |
| dn_hi | output | 1 | Class of offered cell |
| dn_tag | output | TAG_W | Tag of offered cell |
| dn_src | output | SRC_W | Source port of offered cell |
| dn_dly | output | DLY_W | Delay count of offered cell |

## Verification
The bench loads a low-class mix in which one virtual queue is left empty. A ring that did not skip empty queues, or that began anywhere but the local queue, would give the wrong order. It then places a high-class cell in front of low-class traffic and stalls the output. A pointer that moved on a high-class grant or on a stalled offer would change the next low-class pick. A sweep of transit delays around the local cell's age covers the tie, so a wrong tie rule or a reversed comparison would send out the wrong head first. Saturation and overfill are driven past their limits, where a wrapping delay count would show a small value and an overflowing queue would deliver a fifth cell.

// File: rtl/xp_pkg.sv
package xp_pkg;

   // Which queue drives the downstream offer in the current slot.
   typedef enum logic [1:0] {
      SEL_NONE   = 2'd0,
      SEL_HI_LOC = 2'd1,
      SEL_HI_TR  = 2'd2,
      SEL_LO     = 2'd3
   } sel_e;

   // Ring position reserved for the local low-class queue.
   localparam int RING_LOCAL_POS = 0;

endpackage

// File: rtl/xp_fifo.sv
module xp_fifo #(
   parameter int TAG_W = 8,
   parameter int SRC_W = 2,
   parameter int DLY_W = 8,
   parameter int DEPTH = 4,
   parameter bit AGE   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [TAG_W-1:0] in_tag,
   input  logic [SRC_W-1:0] in_src,
   input  logic [DLY_W-1:0] in_dly,
   input  logic             pop,
   output logic [TAG_W-1:0] out_tag,
   output logic [SRC_W-1:0] out_src,
   output logic [DLY_W-1:0] out_dly,
   output logic             empty,
   output logic             full
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("xp_fifo: DEPTH must be at least 2");
   end

   logic [TAG_W-1:0] tag_m [DEPTH];
   logic [SRC_W-1:0] src_m [DEPTH];
   logic [DLY_W-1:0] dly_m [DEPTH];
   logic [PW-1:0]    rp, wp;
   logic [CW-1:0]    cnt;
   logic             do_push, do_pop;

   function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
      return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   assign empty   = (cnt == '0);
   assign full    = (cnt == CW'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rp  <= '0;
         wp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= step(wp);
         if (do_pop)  rp <= step(rp);
         unique case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) begin
         tag_m[wp] <= in_tag;
         src_m[wp] <= in_src;
      end
   end

   if (AGE) begin : g_aging
      // every stored count grows each slot and sticks at all-ones
      always_ff @(posedge clk) begin
         for (int i = 0; i < DEPTH; i++) begin
            if (do_push && wp == PW'(i))
               dly_m[i] <= in_dly;
            else if (dly_m[i] != '1)
               dly_m[i] <= dly_m[i] + 1'b1;
         end
      end
   end else begin : g_frozen
      always_ff @(posedge clk) begin
         if (do_push) dly_m[wp] <= in_dly;
      end
   end

   assign out_tag = tag_m[rp];
   assign out_src = src_m[rp];
   assign out_dly = dly_m[rp];
endmodule

// File: rtl/xp_ring_pick.sv
module xp_ring_pick #(
   parameter int NQ = 4,
   parameter int IW = 2
) (
   input  logic [NQ-1:0] req,
   input  logic [IW-1:0] ptr,
   output logic          any,
   output logic [IW-1:0] gnt
);
   if (NQ < 2) begin : g_bad_nq
      $error("xp_ring_pick: NQ must be at least 2");
   end

   always_comb begin
      any = 1'b0;
      gnt = '0;
      // scan from the far end so the closest requester past ptr wins
      for (int off = NQ - 1; off >= 0; off--) begin
         int s;
         s = int'(ptr) + off;
         if (s >= NQ) s = s - NQ;
         if (req[s]) begin
            any = 1'b1;
            gnt = IW'(s);
         end
      end
   end
endmodule

// File: rtl/xp_age_pick.sv
module xp_age_pick #(
   parameter int DLY_W = 8
) (
   input  logic             loc_ok,
   input  logic             tr_ok,
   input  logic [DLY_W-1:0] loc_dly,
   input  logic [DLY_W-1:0] tr_dly,
   output logic             take_loc,
   output logic             take_tr
);
   // ties go to the cell that has already travelled further
   assign take_tr  = tr_ok && (!loc_ok || (tr_dly >= loc_dly));
   assign take_loc = loc_ok && !take_tr;
endmodule

// File: rtl/xp_cell_sel.sv
module xp_cell_sel #(
   parameter int N_UP  = 3,
   parameter int TAG_W = 8,
   parameter int DLY_W = 8,
   parameter int DEPTH = 4,
   parameter int SRC_W = $clog2(N_UP + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             loc_valid,
   output logic             loc_ready,
   input  logic             loc_hi,
   input  logic [TAG_W-1:0] loc_tag,
   input  logic             up_valid,
   output logic             up_ready,
   input  logic             up_hi,
   input  logic [TAG_W-1:0] up_tag,
   input  logic [SRC_W-1:0] up_src,
   input  logic [DLY_W-1:0] up_dly,
   output logic             dn_valid,
   input  logic             dn_ready,
   output logic             dn_hi,
   output logic [TAG_W-1:0] dn_tag,
   output logic [SRC_W-1:0] dn_src,
   output logic [DLY_W-1:0] dn_dly
);
   import xp_pkg::*;

   localparam int NQ = N_UP + 1;
   localparam logic [SRC_W-1:0] LOCAL_ID = SRC_W'(N_UP);

   if (N_UP < 1)                    begin : g_bad_nup   $error("N_UP must be at least 1");   end
   if (SRC_W < $clog2(N_UP + 1))    begin : g_bad_srcw  $error("SRC_W too narrow for N_UP"); end
   if (DLY_W < 2)                   begin : g_bad_dlyw  $error("DLY_W must be at least 2");  end
   if (TAG_W < 1)                   begin : g_bad_tagw  $error("TAG_W must be at least 1");  end

   // high-class queues
   logic             hl_empty, hl_full, hl_pop;
   logic             ht_empty, ht_full, ht_pop;
   logic [TAG_W-1:0] hl_tag, ht_tag;
   logic [SRC_W-1:0] hl_src, ht_src;
   logic [DLY_W-1:0] hl_dly, ht_dly;

   xp_fifo #(.TAG_W(TAG_W), .SRC_W(SRC_W), .DLY_W(DLY_W), .DEPTH(DEPTH), .AGE(1'b1)) u_hi_loc (
      .clk(clk), .rst_n(rst_n), .push(loc_valid && loc_hi),
      .in_tag(loc_tag), .in_src(LOCAL_ID), .in_dly('0), .pop(hl_pop),
      .out_tag(hl_tag), .out_src(hl_src), .out_dly(hl_dly), .empty(hl_empty), .full(hl_full));

   xp_fifo #(.TAG_W(TAG_W), .SRC_W(SRC_W), .DLY_W(DLY_W), .DEPTH(DEPTH), .AGE(1'b1)) u_hi_tr (
      .clk(clk), .rst_n(rst_n), .push(up_valid && up_hi),
      .in_tag(up_tag), .in_src(up_src), .in_dly(up_dly), .pop(ht_pop),
      .out_tag(ht_tag), .out_src(ht_src), .out_dly(ht_dly), .empty(ht_empty), .full(ht_full));

   // low-class queues: ring position 0 is local, position k+1 is virtual queue k
   logic [TAG_W-1:0] lq_tag [NQ];
   logic [SRC_W-1:0] lq_src [NQ];
   logic [DLY_W-1:0] lq_dly [NQ];
   logic [NQ-1:0]    lq_empty, lq_full, lq_pop, lq_push;

   assign lq_push[RING_LOCAL_POS] = loc_valid && !loc_hi;

   xp_fifo #(.TAG_W(TAG_W), .SRC_W(SRC_W), .DLY_W(DLY_W), .DEPTH(DEPTH), .AGE(1'b0)) u_lo_loc (
      .clk(clk), .rst_n(rst_n), .push(lq_push[RING_LOCAL_POS]),
      .in_tag(loc_tag), .in_src(LOCAL_ID), .in_dly('0), .pop(lq_pop[RING_LOCAL_POS]),
      .out_tag(lq_tag[RING_LOCAL_POS]), .out_src(lq_src[RING_LOCAL_POS]),
      .out_dly(lq_dly[RING_LOCAL_POS]), .empty(lq_empty[RING_LOCAL_POS]),
      .full(lq_full[RING_LOCAL_POS]));

   for (genvar k = 0; k < N_UP; k++) begin : g_vq
      assign lq_push[k+1] = up_valid && !up_hi && (up_src == SRC_W'(k));
      xp_fifo #(.TAG_W(TAG_W), .SRC_W(SRC_W), .DLY_W(DLY_W), .DEPTH(DEPTH), .AGE(1'b0)) u_vq (
         .clk(clk), .rst_n(rst_n), .push(lq_push[k+1]),
         .in_tag(up_tag), .in_src(up_src), .in_dly(up_dly), .pop(lq_pop[k+1]),
         .out_tag(lq_tag[k+1]), .out_src(lq_src[k+1]), .out_dly(lq_dly[k+1]),
         .empty(lq_empty[k+1]), .full(lq_full[k+1]));
   end

   // edge readiness
   logic up_lo_room;
   always_comb begin
      up_lo_room = 1'b0;
      for (int k = 0; k < N_UP; k++)
         if (up_src == SRC_W'(k)) up_lo_room = !lq_full[k+1];
   end
   assign loc_ready = loc_hi ? !hl_full : !lq_full[RING_LOCAL_POS];
   assign up_ready  = up_hi  ? !ht_full : up_lo_room;

   // selection
   logic             take_hl, take_ht, lo_any;
   logic [SRC_W-1:0] ring_ptr, ring_gnt;
   sel_e             sel;
   logic             fire;

   xp_age_pick #(.DLY_W(DLY_W)) u_age (
      .loc_ok(!hl_empty), .tr_ok(!ht_empty), .loc_dly(hl_dly), .tr_dly(ht_dly),
      .take_loc(take_hl), .take_tr(take_ht));

   xp_ring_pick #(.NQ(NQ), .IW(SRC_W)) u_ring (
      .req(~lq_empty), .ptr(ring_ptr), .any(lo_any), .gnt(ring_gnt));

   always_comb begin
      if (take_ht)      sel = SEL_HI_TR;
      else if (take_hl) sel = SEL_HI_LOC;
      else if (lo_any)  sel = SEL_LO;
      else              sel = SEL_NONE;
   end

   always_comb begin
      dn_valid = (sel != SEL_NONE);
      dn_hi    = 1'b0;
      dn_tag   = '0;
      dn_src   = '0;
      dn_dly   = '0;
      unique case (sel)
         SEL_HI_TR:  begin dn_hi = 1'b1; dn_tag = ht_tag; dn_src = ht_src; dn_dly = ht_dly; end
         SEL_HI_LOC: begin dn_hi = 1'b1; dn_tag = hl_tag; dn_src = hl_src; dn_dly = hl_dly; end
         SEL_LO: begin
            for (int q = 0; q < NQ; q++) begin
               if (ring_gnt == SRC_W'(q)) begin
                  dn_tag = lq_tag[q];
                  dn_src = lq_src[q];
                  dn_dly = lq_dly[q];
               end
            end
         end
         default: ;
      endcase
   end

   assign fire   = dn_valid && dn_ready;
   assign hl_pop = fire && (sel == SEL_HI_LOC);
   assign ht_pop = fire && (sel == SEL_HI_TR);
   for (genvar q = 0; q < NQ; q++) begin : g_lo_pop
      assign lq_pop[q] = fire && (sel == SEL_LO) && (ring_gnt == SRC_W'(q));
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         ring_ptr <= SRC_W'(RING_LOCAL_POS);
      else if (fire && sel == SEL_LO)
         ring_ptr <= (ring_gnt == SRC_W'(NQ - 1)) ? '0 : ring_gnt + 1'b1;
   end
endmodule

// File: rtl/xp_cell_sel_chk.sv
module xp_cell_sel_chk #(
   parameter int N_UP  = 3,
   parameter int DLY_W = 8,
   parameter int SRC_W = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             loc_valid,
   input logic             loc_hi,
   input logic             loc_ready,
   input logic             up_valid,
   input logic             up_hi,
   input logic             up_ready,
   input logic             dn_valid,
   input logic             dn_ready,
   input logic             dn_hi,
   input logic [DLY_W-1:0] dn_dly,
   input logic             hl_empty,
   input logic             ht_empty,
   input logic             hl_full,
   input logic             ht_full,
   input logic [DLY_W-1:0] hl_dly,
   input logic [DLY_W-1:0] ht_dly,
   input logic             lo_any,
   input logic [SRC_W-1:0] ring_ptr
);
   // R2: a low-class offer only when both high queues are empty
   p_hol_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_valid && !dn_hi) |-> (hl_empty && ht_empty));

   // R9: nothing offered only when nothing is queued
   p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !dn_valid |-> (hl_empty && ht_empty && !lo_any));

   // R4: with both high heads present the older one is offered
   p_older_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_valid && dn_hi && !hl_empty && !ht_empty) |->
         (dn_dly == ((ht_dly >= hl_dly) ? ht_dly : hl_dly)));

   // R3: a full high queue never reports room to its sender
   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (hl_full && loc_valid && loc_hi) |-> !loc_ready);

   p_no_overflow_tr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ht_full && up_valid && up_hi) |-> !up_ready);

   // R8: the ring pointer moves only on a forwarded low-class cell
   p_ptr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(dn_valid && dn_ready && !dn_hi) |=> $stable(ring_ptr));

   // R7: the pointer always names a real ring position
   p_ptr_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ring_ptr <= SRC_W'(N_UP));
endmodule

bind xp_cell_sel xp_cell_sel_chk #(.N_UP(N_UP), .DLY_W(DLY_W), .SRC_W(SRC_W)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .loc_valid(loc_valid), .loc_hi(loc_hi), .loc_ready(loc_ready),
   .up_valid(up_valid), .up_hi(up_hi), .up_ready(up_ready),
   .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_hi(dn_hi), .dn_dly(dn_dly),
   .hl_empty(hl_empty), .ht_empty(ht_empty), .hl_full(hl_full), .ht_full(ht_full),
   .hl_dly(hl_dly), .ht_dly(ht_dly), .lo_any(lo_any), .ring_ptr(ring_ptr));

// File: tb/test_xp_cell_sel.sv
module test_xp_cell_sel;
   localparam int CLK_P = 10;
   localparam int N_UP  = 3;
   localparam int TAG_W = 8;
   localparam int DLY_W = 4;
   localparam int DEPTH = 4;
   localparam int SRC_W = 2;
   localparam int LOC   = N_UP;
   localparam int DMAX  = (1 << DLY_W) - 1;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             loc_valid = 1'b0, loc_hi = 1'b0;
   logic [TAG_W-1:0] loc_tag = '0;
   logic             up_valid = 1'b0, up_hi = 1'b0;
   logic [TAG_W-1:0] up_tag = '0;
   logic [SRC_W-1:0] up_src = '0;
   logic [DLY_W-1:0] up_dly = '0;
   logic             dn_ready = 1'b0;
   logic             loc_ready, up_ready, dn_valid, dn_hi;
   logic [TAG_W-1:0] dn_tag;
   logic [SRC_W-1:0] dn_src;
   logic [DLY_W-1:0] dn_dly;

   int cyc = 0;
   int nchk = 0;
   int nfail = 0;

   always #(CLK_P / 2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   xp_cell_sel #(.N_UP(N_UP), .TAG_W(TAG_W), .DLY_W(DLY_W), .DEPTH(DEPTH), .SRC_W(SRC_W)) i_xp_cell_sel (
      .clk(clk), .rst_n(rst_n),
      .loc_valid(loc_valid), .loc_ready(loc_ready), .loc_hi(loc_hi), .loc_tag(loc_tag),
      .up_valid(up_valid), .up_ready(up_ready), .up_hi(up_hi), .up_tag(up_tag),
      .up_src(up_src), .up_dly(up_dly),
      .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_hi(dn_hi), .dn_tag(dn_tag),
      .dn_src(dn_src), .dn_dly(dn_dly));

   task automatic ceq(input string req, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int aged(input int d0, input int e);
      int v;
      v = d0 + (cyc - e);
      return (v > DMAX) ? DMAX : v;
   endfunction

   task automatic push_loc(input bit hi, input int tag, output int e);
      @(negedge clk);
      loc_valid = 1'b1; loc_hi = hi; loc_tag = TAG_W'(tag);
      @(posedge clk); #1;
      e = cyc;
      loc_valid = 1'b0;
   endtask

   task automatic push_up(input bit hi, input int src, input int tag, input int dly, output int e);
      @(negedge clk);
      up_valid = 1'b1; up_hi = hi; up_src = SRC_W'(src); up_tag = TAG_W'(tag); up_dly = DLY_W'(dly);
      @(posedge clk); #1;
      e = cyc;
      up_valid = 1'b0;
   endtask

   task automatic pop_chk(input string req, input int hi, input int src, input int tag, input int dly);
      @(negedge clk);
      ceq({req, " valid"}, int'(dn_valid), 1);
      ceq({req, " class"}, int'(dn_hi), hi);
      ceq({req, " src"}, int'(dn_src), src);
      ceq({req, " tag"}, int'(dn_tag), tag);
      if (dly >= 0) ceq({req, " dly"}, int'(dn_dly), dly);
      dn_ready = 1'b1;
      @(posedge clk); #1;
      dn_ready = 1'b0;
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      summary();
      $finish;
   end

   initial begin
      int e, e1, e2;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state
      @(negedge clk);
      ceq("R1 dn_valid", int'(dn_valid), 0);
      loc_hi = 1'b1; up_hi = 1'b1; #1;
      ceq("R1 loc_ready hi", int'(loc_ready), 1);
      ceq("R1 up_ready hi", int'(up_ready), 1);
      loc_hi = 1'b0; up_hi = 1'b0; up_src = 2'd2; #1;
      ceq("R1 loc_ready lo", int'(loc_ready), 1);
      ceq("R1 up_ready lo", int'(up_ready), 1);

      // R6 R7 R10: ring order from the local position, VQ1 left empty
      push_loc(1'b0, 'h10, e);
      push_loc(1'b0, 'h11, e);
      push_up(1'b0, 0, 'h20, 7, e);
      push_up(1'b0, 0, 'h21, 7, e);
      push_up(1'b0, 2, 'h40, 9, e);
      repeat (3) @(posedge clk);
      pop_chk("R7 local first", 0, LOC, 'h10, 0);
      pop_chk("R10 vq0 dly kept", 0, 0, 'h20, 7);
      pop_chk("R7 skip empty vq1", 0, 2, 'h40, 9);
      pop_chk("R7 wrap to local", 0, LOC, 'h11, 0);
      pop_chk("R6 vq0 order", 0, 0, 'h21, 7);
      @(negedge clk);
      ceq("R9 idle when empty", int'(dn_valid), 0);

      // R2 R8: ring pointer now at position 2 (vq1)
      push_loc(1'b0, 'h12, e);
      push_up(1'b0, 0, 'h22, 1, e);
      push_up(1'b0, 1, 'h30, 1, e);
      push_loc(1'b1, 'h50, e);
      pop_chk("R2 high before low", 1, LOC, 'h50, aged(0, e));
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         ceq("R8 stalled offer tag", int'(dn_tag), 'h30);
      end
      pop_chk("R8 ptr kept vq1", 0, 1, 'h30, 1);
      pop_chk("R7 skip vq2 to local", 0, LOC, 'h12, 0);
      pop_chk("R7 then vq0", 0, 0, 'h22, 1);

      // R4: sweep transit delay around local age, tie included
      for (int d = 0; d < 8; d++) begin
         int la, ta;
         push_loc(1'b1, 'h60 + d, e1);
         push_up(1'b1, 1, 'h70 + d, d, e2);
         la = aged(0, e1);
         ta = aged(d, e2);
         if (ta >= la) begin
            pop_chk("R4 transit older or tie", 1, 1, 'h70 + d, ta);
            pop_chk("R4 local second", 1, LOC, 'h60 + d, aged(0, e1));
         end else begin
            pop_chk("R4 local older", 1, LOC, 'h60 + d, la);
            pop_chk("R4 transit second", 1, 1, 'h70 + d, aged(d, e2));
         end
      end

      // R5: saturation of the delay count
      push_loc(1'b1, 'h80, e);
      repeat (20) @(posedge clk);
      #1;
      pop_chk("R5 local saturates", 1, LOC, 'h80, DMAX);
      push_up(1'b1, 2, 'h81, 14, e);
      repeat (2) @(posedge clk);
      #1;
      pop_chk("R5 transit saturates", 1, 2, 'h81, aged(14, e));

      // R3: fill vq1 and local high queue, attempt overfill
      for (int i = 0; i < DEPTH; i++) push_up(1'b0, 1, 'h90 + i, 3, e);
      @(negedge clk);
      up_hi = 1'b0; up_src = 2'd1; #1;
      ceq("R3 full vq1 not ready", int'(up_ready), 0);
      up_src = 2'd0; #1;
      ceq("R3 vq0 still ready", int'(up_ready), 1);
      up_hi = 1'b1; #1;
      ceq("R3 high transit ready", int'(up_ready), 1);
      push_up(1'b0, 1, 'h9F, 3, e);
      for (int i = 0; i < DEPTH; i++) push_loc(1'b1, 'hA0 + i, e);
      @(negedge clk);
      loc_hi = 1'b1; #1;
      ceq("R3 full local high not ready", int'(loc_ready), 0);
      loc_hi = 1'b0; #1;
      ceq("R3 local low ready", int'(loc_ready), 1);
      push_loc(1'b1, 'hAF, e);
      for (int i = 0; i < DEPTH; i++) pop_chk("R3 local high drain", 1, LOC, 'hA0 + i, -1);
      for (int i = 0; i < DEPTH; i++) pop_chk("R3 vq1 drain", 0, 1, 'h90 + i, 3);
      @(negedge clk);
      ceq("R3 overfill dropped", int'(dn_valid), 0);

      summary();
      $finish;
   end
endmodule